// File: doc/BRIEF.md
# PWM Compare Output Waveform Generator

This block holds one free-running counter with a width set by a parameter, and a set of compare channels that share it. Each channel turns its compare value and a 2-bit output-mode code into a level on its own waveform pin. A 4-bit waveform-mode input picks the counting style. In single-slope (fast) PWM the counter counts up to a programmed TOP and then wraps to zero. In dual-slope (phase-correct) PWM it counts up to TOP and then back down to zero.

What a mode code means depends on the counting style. In single-slope mode the pin is set or cleared at the wrap and takes the opposite level on a match. In dual-slope mode the match action depends on the direction in which the counter leaves the matching value. Toggle-on-match is available only on channel 0, and only for some waveform modes. Each channel has a flag that reports whether its waveform currently drives the pin. While the flag is low, the waveform register keeps its last level.

Top module: `pwm_wavegen`

## Requirements
- R1: A synchronous reset sets the counter to zero, sets the direction to up and drives every `wave_out` bit low.
- R2: Waveform modes 14 and 15 select single-slope counting, and modes 8 to 11 select dual-slope counting. In every other mode the counter holds its value and every `pin_conn` bit is low.
- R3: In single-slope mode the counter goes up by one on each enabled cycle. After a value equal to or above `top_val`, the next value is 0.
- R4: In dual-slope mode a counter value of 0 is always left upward and a value at or above `top_val` is always left downward. Any other value continues in the current direction.
- R5: While `en` is low, the counter and every `wave_out` bit hold.
- R6: Mode code 00 gives `pin_conn` low. A channel whose `pin_conn` is low keeps its `wave_out` level.
- R7: Single-slope mode with code 1x (bit 1 set): the counter reaching TOP drives the pin to the inverse of code bit 0, and a match drives it to code bit 0. The TOP action wins, so a compare value equal to TOP gives a constant level. With code 10 and compare value c ≤ TOP, the pin is high for c+1 out of every TOP+1 cycles.
- R8: Dual-slope mode with code 1x: a match when the counter leaves upward drives the pin to code bit 0, and a match when it leaves downward drives it to the inverse of code bit 0. With code 10, a compare value of TOP holds the pin high and a compare value of 0 holds it low.
- R9: Code 01 on channel 0 with waveform mode 15, 9 or 11 sets `pin_conn[0]` high and toggles `wave_out[0]` on every match.
- R10: Code 01 on channels 1 and above, or on channel 0 in any other waveform mode, gives `pin_conn` low.
- R11: A channel action decided in an enabled cycle shows on `wave_out` right after the clock edge that ends that cycle. `pin_conn` follows the current inputs combinationally.

Channel i uses `cmp_val[i*CNT_W +: CNT_W]` and `com_mode[2*i+1:2*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| wgm | input | 4 | Waveform mode |
| top_val | input | CNT_W | Counter TOP value |
| cmp_val | input | CH_N*CNT_W | Compare values, channel i in slice i |
| com_mode | input | 2*CH_N | Output-mode codes, two bits per channel |
| wave_out | output | CH_N | Waveform pins |
| pin_conn | output | CH_N | High while the channel's waveform drives its pin |

## Verification
A wrong counter value or a wrong direction bit shows as a pin edge in the wrong cycle. The error reaches `wave_out` one edge after the counter passes the affected compare value, and it shows on every connected channel at once. A wrong waveform register shows as a wrong level in the very next cycle and stays wrong until the next set, clear or toggle event. The comparisons run every cycle, so they catch such errors within one PWM period. The duty counts catch errors that shift an edge by a cycle without changing the shape of the waveform.

// File: rtl/pwm_wavegen_pkg.sv
package pwm_wavegen_pkg;

   typedef enum logic [1:0] {
      STYLE_IDLE = 2'd0,
      STYLE_SINGLE = 2'd1,
      STYLE_DUAL = 2'd2
   } count_style_e;

   function automatic count_style_e style_of(input logic [3:0] w);
      if (w == 4'd14 || w == 4'd15) return STYLE_SINGLE;
      if (w >= 4'd8 && w <= 4'd11) return STYLE_DUAL;
      return STYLE_IDLE;
   endfunction

   function automatic logic toggle_allowed(input logic [3:0] w);
      return (w == 4'd15) || (w == 4'd9) || (w == 4'd11);
   endfunction

endpackage

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core
   import pwm_wavegen_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  count_style_e     style,
   input  logic [CNT_W-1:0] top_val,
   output logic [CNT_W-1:0] cnt,
   output logic             at_top,
   output logic             leave_up
);

   logic up_q;

   assign at_top = (cnt >= top_val);
   // value 0 always leaves upward, TOP (or above) always leaves downward
   assign leave_up = (cnt == '0) ? 1'b1 : (at_top ? 1'b0 : up_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         up_q <= 1'b1;
      end else if (en) begin
         case (style)
            STYLE_SINGLE: begin
               cnt  <= at_top ? '0 : cnt + 1'b1;
               up_q <= 1'b1;
            end
            STYLE_DUAL: begin
               cnt  <= leave_up ? cnt + 1'b1 : cnt - 1'b1;
               up_q <= leave_up;
            end
            default: begin
               cnt  <= cnt;
               up_q <= up_q;
            end
         endcase
      end
   end

endmodule

// File: rtl/pwm_out_unit.sv
module pwm_out_unit
   import pwm_wavegen_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter bit PRIMARY = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  count_style_e     style,
   input  logic             tog_ok,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] cnt,
   input  logic             at_top,
   input  logic             leave_up,
   output logic             wave,
   output logic             conn
);

   logic match;
   logic tog_conn;
   logic wave_nx;

   assign match = (cnt == cmp);

   generate
      if (PRIMARY) begin : g_tog
         assign tog_conn = (mode == 2'b01) && tog_ok;
      end else begin : g_no_tog
         assign tog_conn = 1'b0;
      end
   endgenerate

   assign conn = (style != STYLE_IDLE) && (mode[1] || tog_conn);

   always_comb begin
      wave_nx = wave;
      if (!mode[1]) begin
         if (match) wave_nx = ~wave;
      end else if (style == STYLE_SINGLE) begin
         if (at_top) wave_nx = ~mode[0];
         else if (match) wave_nx = mode[0];
      end else begin
         if (match) wave_nx = leave_up ? mode[0] : ~mode[0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) wave <= 1'b0;
      else if (en && conn) wave <= wave_nx;
   end

endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
   import pwm_wavegen_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int CH_N = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  en,
   input  logic [3:0]            wgm,
   input  logic [CNT_W-1:0]      top_val,
   input  logic [CH_N*CNT_W-1:0] cmp_val,
   input  logic [2*CH_N-1:0]     com_mode,
   output logic [CH_N-1:0]       wave_out,
   output logic [CH_N-1:0]       pin_conn
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_wavegen: CNT_W must lie in 2..32");
      end
      if (CH_N < 1 || CH_N > 8) begin : g_bad_chans
         $error("pwm_wavegen: CH_N must lie in 1..8");
      end
   endgenerate

   count_style_e     style;
   logic             tog_ok;
   logic [CNT_W-1:0] cnt_q;
   logic             at_top;
   logic             leave_up;

   assign style  = style_of(wgm);
   assign tog_ok = toggle_allowed(wgm);

   pwm_cnt_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .style   (style),
      .top_val (top_val),
      .cnt     (cnt_q),
      .at_top  (at_top),
      .leave_up(leave_up)
   );

   for (genvar i = 0; i < CH_N; i++) begin : g_ch
      pwm_out_unit #(.CNT_W(CNT_W), .PRIMARY(i == 0)) u_out (
         .clk     (clk),
         .rst     (rst),
         .en      (en),
         .style   (style),
         .tog_ok  (tog_ok),
         .mode    (com_mode[2*i +: 2]),
         .cmp     (cmp_val[i*CNT_W +: CNT_W]),
         .cnt     (cnt_q),
         .at_top  (at_top),
         .leave_up(leave_up),
         .wave    (wave_out[i]),
         .conn    (pin_conn[i])
      );
   end

endmodule

// File: rtl/pwm_wavegen_chk.sv
module pwm_wavegen_chk #(
   parameter int CNT_W = 16,
   parameter int CH_N = 3
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  en,
   input logic [3:0]            wgm,
   input logic [CNT_W-1:0]      top_val,
   input logic [CNT_W-1:0]      cmp_a,
   input logic [2*CH_N-1:0]     com_mode,
   input logic [CH_N-1:0]       wave_out,
   input logic [CH_N-1:0]       pin_conn,
   input logic [CNT_W-1:0]      cnt
);

   logic is_single, is_dual;
   assign is_single = (wgm == 4'd14) || (wgm == 4'd15);
   assign is_dual   = (wgm >= 4'd8) && (wgm <= 4'd11);

   // R1: reset leaves counter and pins at zero
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) && !rst |-> (cnt == '0) && (wave_out == '0));

   // R3: single-slope wrap after TOP
   assert_single_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      en && is_single && (cnt >= top_val) |=> cnt == '0);

   // R5: disabled cycle holds counter
   assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(cnt) && $stable(wave_out));

   // R2: undefined modes disconnect all pins
   assert_idle_disconnect_R2: assert property (@(posedge clk) disable iff (rst)
      !is_single && !is_dual |-> pin_conn == '0);

   for (genvar i = 0; i < CH_N; i++) begin : g_ch
      // R6: a disconnected channel keeps its level
      assert_disc_hold_R6: assert property (@(posedge clk) disable iff (rst)
         !pin_conn[i] |=> $stable(wave_out[i]));
      if (i > 0) begin : g_sec
         // R10: toggle code never connects a secondary channel
         assert_sec_toggle_R10: assert property (@(posedge clk) disable iff (rst)
            com_mode[2*i +: 2] == 2'b01 |-> !pin_conn[i]);
      end
   end

   // R7: reaching TOP in single slope drives channel 0 to its start level
   assert_single_top_R7: assert property (@(posedge clk) disable iff (rst)
      en && is_single && com_mode[1] && (cnt >= top_val)
      |=> wave_out[0] == !$past(com_mode[0]));

   // R8: match at zero in dual slope is an upward match
   assert_dual_zero_R8: assert property (@(posedge clk) disable iff (rst)
      en && is_dual && com_mode[1] && (cnt == '0) && (cmp_a == '0)
      |=> wave_out[0] == $past(com_mode[0]));

   // R9: toggle on match for channel 0
   assert_toggle_R9: assert property (@(posedge clk) disable iff (rst)
      en && pin_conn[0] && (com_mode[1:0] == 2'b01) && (cnt == cmp_a)
      |=> wave_out[0] != $past(wave_out[0]));

endmodule

bind pwm_wavegen pwm_wavegen_chk #(.CNT_W(CNT_W), .CH_N(CH_N)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .en      (en),
   .wgm     (wgm),
   .top_val (top_val),
   .cmp_a   (cmp_val[CNT_W-1:0]),
   .com_mode(com_mode),
   .wave_out(wave_out),
   .pin_conn(pin_conn),
   .cnt     (cnt_q)
);

// File: tb/tb_pwm_wavegen.sv
`timescale 1ns/1ps
module tb_pwm_wavegen;
   localparam int W = 16;
   localparam int N = 3;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           en = 1'b0;
   logic [3:0]     wgm = 4'd14;
   logic [W-1:0]   top_val = 16'd5;
   logic [N*W-1:0] cmp_val = '0;
   logic [2*N-1:0] com_mode = '0;
   logic [N-1:0]   wave_out, pin_conn;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pwm_wavegen #(.CNT_W(W), .CH_N(N)) dut (
      .clk(clk), .rst(rst), .en(en), .wgm(wgm), .top_val(top_val),
      .cmp_val(cmp_val), .com_mode(com_mode),
      .wave_out(wave_out), .pin_conn(pin_conn));

   // reference model built from the requirements
   int       m_cnt;
   bit       m_up;
   bit [N-1:0] m_out;

   function automatic bit m_single(); return wgm == 14 || wgm == 15; endfunction
   function automatic bit m_dual(); return wgm >= 8 && wgm <= 11; endfunction
   function automatic bit m_conn(int ch);
      bit [1:0] c = com_mode[2*ch +: 2];
      if (!m_single() && !m_dual()) return 1'b0;   // R2
      if (c[1]) return 1'b1;
      if (c == 2'b01 && ch == 0 && (wgm == 15 || wgm == 9 || wgm == 11)) return 1'b1; // R9
      return 1'b0;                                   // R6 R10
   endfunction
   function automatic string m_tag(int ch);
      bit [1:0] c = com_mode[2*ch +: 2];
      if (!m_single() && !m_dual()) return "R2";
      if (c == 2'b00) return "R6";
      if (c == 2'b01) return m_conn(ch) ? "R9" : "R10";
      return m_single() ? "R7" : "R8";
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt <= 0; m_up <= 1'b1; m_out <= '0;     // R1
      end else if (en && (m_single() || m_dual())) begin
         bit lu;
         int t;
         t = int'(top_val);
         lu = (m_cnt == 0) ? 1'b1 : ((m_cnt >= t) ? 1'b0 : m_up);  // R4
         for (int ch = 0; ch < N; ch++) begin
            bit [1:0] c;
            bit hit;
            c = com_mode[2*ch +: 2];
            hit = (m_cnt == int'(cmp_val[ch*W +: W]));
            if (m_conn(ch)) begin
               if (!c[1]) begin
                  if (hit) m_out[ch] <= ~m_out[ch];
               end else if (m_single()) begin
                  if (m_cnt >= t) m_out[ch] <= ~c[0];
                  else if (hit) m_out[ch] <= c[0];
               end else if (hit) begin
                  m_out[ch] <= lu ? c[0] : ~c[0];
               end
            end
         end
         if (m_single()) begin
            m_cnt <= (m_cnt >= t) ? 0 : m_cnt + 1;   // R3
            m_up <= 1'b1;
         end else begin
            m_cnt <= lu ? m_cnt + 1 : m_cnt - 1;
            m_up <= lu;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (wgm=%0d top=%0d com=%b t=%0t)",
                  req, act, exp, wgm, top_val, com_mode, $time);
      end
   endtask

   // R11: outputs compared one half period after each edge
   task automatic step_cmp(input bit en_nx);
      @(negedge clk);
      for (int ch = 0; ch < N; ch++) begin
         check(wave_out[ch] == m_out[ch], m_tag(ch), wave_out[ch], m_out[ch]);
         check(pin_conn[ch] == m_conn(ch), m_tag(ch), pin_conn[ch], m_conn(ch));
      end
      en = en_nx;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; en = 1'b0;
      @(negedge clk); rst = 1'b0;
      check(wave_out == '0, "R1", wave_out, 0);
      en = 1'b1;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int modes[7] = '{14, 15, 8, 9, 10, 11, 3};
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // sweep: every mode code, every compare offset, both styles, gated enable
      foreach (modes[mi]) begin
         for (int tp = 4; tp <= 5; tp++) begin
            for (int code = 0; code < 4; code++) begin
               for (int base = 0; base <= tp; base++) begin
                  wgm = 4'(modes[mi]);
                  top_val = W'(tp);
                  com_mode = {2'(code), 2'(code), 2'(code)};
                  cmp_val = {W'((base + tp) % (tp + 1)), W'((base + 1) % (tp + 1)), W'(base)};
                  do_reset();
                  for (int k = 0; k < 4 * (tp + 1); k++) step_cmp((k % 7) != 3);
               end
            end
         end
      end

      // R5: enable low holds all pins while inputs move
      wgm = 4'd15; top_val = 16'd5; com_mode = 6'b10_11_01;
      cmp_val = {16'd2, 16'd3, 16'd1};
      do_reset();
      repeat (8) step_cmp(1'b1);
      begin
         logic [N-1:0] held;
         step_cmp(1'b0);
         held = wave_out;
         for (int k = 0; k < 6; k++) begin
            step_cmp(1'b0);
            check(wave_out == held, "R5", wave_out, held);
         end
      end

      // R3 R7: single-slope duty, code 10 on channel 0
      for (int c = 0; c <= 5; c++) begin
         int hi;
         wgm = 4'd14; top_val = 16'd5; com_mode = 6'b00_00_10;
         cmp_val = {16'd0, 16'd0, W'(c)};
         do_reset();
         repeat (6) step_cmp(1'b1);
         hi = 0;
         for (int k = 0; k < 12; k++) begin
            step_cmp(1'b1);
            hi += int'(wave_out[0]);
         end
         check(hi == 2 * (c + 1), "R3 R7 duty", hi, 2 * (c + 1));
      end

      // R4 R8: dual-slope constant levels at compare 0 and TOP
      for (int e = 0; e < 2; e++) begin
         int hi, expv;
         wgm = 4'd10; top_val = 16'd4; com_mode = 6'b00_00_10;
         cmp_val = {16'd0, 16'd0, (e == 0) ? 16'd0 : 16'd4};
         do_reset();
         repeat (8) step_cmp(1'b1);
         hi = 0;
         for (int k = 0; k < 16; k++) begin
            step_cmp(1'b1);
            hi += int'(wave_out[0]);
         end
         expv = (e == 0) ? 0 : 16;
         check(hi == expv, "R4 R8 constant", hi, expv);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule